// File: doc/BRIEF.md
# Three-Source Interrupt Control Register

This block holds one 32-bit interrupt register that serves three event sources: an error condition, a vertical-blank event and a command-packet completion. Each hardware source raises a one-cycle pulse. The block latches that pulse as a pending request and drives one combined interrupt line. The line goes high for any source whose enable bit is set while its request is pending.

Software reads the register through a plain read/write port. Each source owns a 4-bit field, and each field carries its own qualifier bit. A write changes only the fields whose qualifier is 1 in the written data. One store can therefore acknowledge or re-enable one source and leave the other two untouched.

Top module: `intr_reg3`

## Requirements
- R1: Field layout. The error source uses bits 3:0, vertical blank uses bits 11:8 and packet completion uses bits 19:16, so source i starts at bit 8*i. Inside a field, bit 0 is the enable, bit 1 is the pending request and bit 2 is the write qualifier.
- R2: After reset every enable and every pending bit is 0, the read data is 0 and the interrupt output is 0.
- R3: An event pulse on a source sets that source's pending bit on the next clock edge, whatever its enable bit holds.
- R4: A write with a field's qualifier at 1 loads that field's enable bit from the written data.
- R5: A write with a field's qualifier at 1 and its pending bit at 0 clears that source's pending request. Writing 1 to the pending bit leaves the request unchanged.
- R6: A write with a field's qualifier at 0 changes neither the enable nor the pending bit of that field.
- R7: If an event pulse arrives in the same cycle as a write that clears the same source, the pending bit ends up set.
- R8: The interrupt output is a register. One clock after the state changes, it equals the OR over the sources of (enable AND pending).
- R9: The qualifier bit, the top bit of every field and every bit outside the three fields read as 0.
- R10: While the write strobe is low, the write data has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 3 | Event pulses: bit 0 error, bit 1 vertical blank, bit 2 packet done |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default data width of 32. With that width all three fields and the unused bits above bit 19 lie on the port, so one test pass can write to and read from every field and every unused bit. Each scenario loops over the three sources. This covers qualified and unqualified writes to each field alone, an event colliding with a clearing write, and the one-cycle lag of the interrupt behind the pending state.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_SRC      = 3;
  localparam int FIELD_STRIDE = 8;
  localparam int BIT_EN       = 0;
  localparam int BIT_PEND     = 1;
  localparam int BIT_QUAL     = 2;

  typedef struct packed {
    logic [NUM_SRC-1:0] updEn;
    logic [NUM_SRC-1:0] enVal;
    logic [NUM_SRC-1:0] clrPend;
  } strobe_t;
endpackage

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      strb.updEn[i]   = wrEn & wrData[i*FIELD_STRIDE + BIT_QUAL];
      strb.enVal[i]   = wrData[i*FIELD_STRIDE + BIT_EN];
      strb.clrPend[i] = wrEn & wrData[i*FIELD_STRIDE + BIT_QUAL]
                        & ~wrData[i*FIELD_STRIDE + BIT_PEND];
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gChk
      AST_CLR_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rstN)
        strb.clrPend[g] |-> wrEn && wrData[g*FIELD_STRIDE + BIT_QUAL]); // R5
      AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
        !wrEn |-> (strb.updEn[g] == 1'b0) && (strb.clrPend[g] == 1'b0)); // R10
    end
  endgenerate
endmodule

// File: rtl/intr_datapath.sv
module intr_datapath
  import intr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  strobe_t            strb,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] pendReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      pendReg <= '0;
      irqOut  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strb.updEn[i]) enReg[i] <= strb.enVal[i];
        pendReg[i] <= evtPulse[i] | (pendReg[i] & ~strb.clrPend[i]);
      end
      irqOut <= |(enReg & pendReg);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      rdData[i*FIELD_STRIDE + BIT_EN]   = enReg[i];
      rdData[i*FIELD_STRIDE + BIT_PEND] = pendReg[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gChk
      AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
        evtPulse[g] |=> pendReg[g]); // R3
      AST_NO_SPONT_PEND: assert property (@(posedge clk) disable iff (!rstN)
        !pendReg[g] && !evtPulse[g] |=> !pendReg[g]); // R5
      AST_UNQUAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !strb.updEn[g] |=> $stable(enReg[g])); // R6
      AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
        strb.clrPend[g] && !evtPulse[g] |=> !pendReg[g]); // R5
    end
  endgenerate

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enReg & pendReg) == '0 |=> !irqOut); // R8
endmodule

// File: rtl/intr_reg3.sv
module intr_reg3
  import intr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  strobe_t strb;

  intr_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  intr_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .strb(strb),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/test_intr_reg3.sv
`timescale 1ns/1ps
module test_intr_reg3;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  evtPulse = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  intr_reg3 i_intr_reg3 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [31:0] fld(int s, logic en, logic pd, logic q);
    logic [31:0] v = '0;
    v[8*s]   = en;
    v[8*s+1] = pd;
    v[8*s+2] = q;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [2:0] ev, logic we, logic [31:0] d);
    evtPulse = ev; wrEn = we; wrData = d;
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    chk("R2 rdData", rdData, 32'h0);
    chk("R2 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tEventLatch();
    for (int s = 0; s < 3; s++) begin
      doReset();
      cyc(3'b1 << s, 1'b0, '0);
      chk("R3/R1 pending set with enable low", rdData, fld(s, 0, 1, 0));
      @(negedge clk);
      chk("R8 irq stays low when disabled", {31'b0, irqOut}, 32'h0);
    end
  endtask

  task automatic tEnableWrite();
    for (int s = 0; s < 3; s++) begin
      doReset();
      cyc('0, 1'b1, fld(s, 1, 1, 1));
      chk("R4/R5 enable loaded, pend 1 write no set", rdData, fld(s, 1, 0, 0));
      cyc('0, 1'b1, fld(s, 0, 1, 1));
      chk("R4 enable cleared", rdData, 32'h0);
    end
  endtask

  task automatic tQualHold();
    doReset();
    cyc(3'b111, 1'b1, fld(0, 1, 1, 1) | fld(1, 1, 1, 1) | fld(2, 1, 1, 1));
    for (int s = 0; s < 3; s++) begin
      logic [31:0] exp;
      exp = fld(0, 1, 1, 0) | fld(1, 1, 1, 0) | fld(2, 1, 1, 0);
      cyc('0, 1'b1, fld(s, 0, 0, 0));
      chk("R6 unqualified field unchanged", rdData, exp);
    end
    cyc('0, 1'b1, fld(1, 0, 0, 1));
    chk("R6 only qualified field changes", rdData,
        fld(0, 1, 1, 0) | fld(2, 1, 1, 0));
    cyc('0, 1'b0, 32'hFFFF_FFFF & ~(fld(0, 0, 0, 1)) | fld(0, 0, 0, 1));
    chk("R10 write strobe low ignored", rdData,
        fld(0, 1, 1, 0) | fld(2, 1, 1, 0));
  endtask

  task automatic tClear();
    for (int s = 0; s < 3; s++) begin
      doReset();
      cyc(3'b1 << s, 1'b1, fld(s, 1, 1, 1));
      chk("R3 pend set alongside enable write", rdData, fld(s, 1, 1, 0));
      cyc('0, 1'b1, fld(s, 1, 0, 1));
      chk("R5 pend cleared, enable kept", rdData, fld(s, 1, 0, 0));
    end
  endtask

  task automatic tCollision();
    for (int s = 0; s < 3; s++) begin
      doReset();
      cyc(3'b1 << s, 1'b0, '0);
      cyc(3'b1 << s, 1'b1, fld(s, 0, 0, 1));
      chk("R7 event wins over clear", rdData, fld(s, 0, 1, 0));
    end
  endtask

  task automatic tIrq();
    for (int s = 0; s < 3; s++) begin
      doReset();
      cyc('0, 1'b1, fld(s, 1, 0, 1));
      cyc(3'b1 << s, 1'b0, '0);
      chk("R8 irq lags pending by one clock", {31'b0, irqOut}, 32'h0);
      @(negedge clk);
      chk("R8 irq high", {31'b0, irqOut}, 32'h1);
      cyc('0, 1'b1, fld(s, 1, 0, 1));
      chk("R8 irq still high one clock after clear", {31'b0, irqOut}, 32'h1);
      @(negedge clk);
      chk("R8 irq low after clear", {31'b0, irqOut}, 32'h0);
    end
  endtask

  task automatic tReadZero();
    doReset();
    cyc(3'b111, 1'b1, 32'hFFFF_FFFF);
    chk("R9 unused bits read zero", rdData,
        fld(0, 1, 1, 0) | fld(1, 1, 1, 0) | fld(2, 1, 1, 0));
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        tReset();
        tEventLatch();
        tEnableWrite();
        tQualHold();
        tClear();
        tCollision();
        tIrq();
        tReadZero();
      end
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule